// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Decoder

This block is the device-side control for a byte-wide static memory whose host strobes arrive without a clock. A fast internal clock samples three active-low strobes (chip select, write strobe, output enable) and a protect input. It turns them into read, write and idle cycles, and it holds a small register array as the storage behind them. A write occupies exactly the overlap of chip select and write strobe, so the later of the two falling strobes opens it and the earlier rising strobe closes it. Once a write closes, the write strobe has to stay high for a set number of samples before any new cycle is decoded.

The state machine has four states. ST_IDLE has no cycle open. ST_READ drives the array byte at the current address. ST_WRITE captures the address and data. ST_RECOVER waits out the recovery interval. These are the transitions. From ST_IDLE or ST_READ the machine goes to ST_WRITE when both strobes are low. It goes to ST_READ when chip select is low and the write strobe is high. It goes to ST_IDLE otherwise. ST_WRITE moves to ST_RECOVER on the first sample that shows either strobe released. ST_RECOVER returns to ST_IDLE on the sample that completes the recovery count. A raised protect input sends every state to ST_IDLE.

Top module: `sram_cycle_decoder`

## Requirements
- R1: While reset is low and on the first edge after it, the outputs `data_oe`, `rdata`, `commit`, `addr_err` and `rec_viol` are all zero, and every array byte reads back as zero.
- R2: A sample with `chip_sel_n`=0 and `wr_strobe_n`=1 puts the block in ST_READ at that edge. `data_oe` is 1 only in ST_READ while `out_en_n`=0 and `protect`=0. `rdata` equals the array byte at the current `addr` when `data_oe` is 1, and it is zero otherwise.
- R3: A write opens on the first sample in which both `chip_sel_n` and `wr_strobe_n` are low. It does not matter which strobe fell first. The address is captured on that sample. `wdata` is captured on every sample of the overlap, and the last one is the byte that gets stored.
- R4: A write closes on the first sample that shows either strobe high. At that edge the stored byte is written to the captured address, and `commit` goes high for exactly one cycle.
- R5: `data_oe` stays 0 in ST_IDLE, ST_WRITE and ST_RECOVER, and this holds even when `out_en_n`=0.
- R6: If `addr` differs from the captured address on any overlap sample, the close of that write raises `addr_err` for one cycle. In that case `commit` stays 0 and the array is left unchanged.
- R7: After a write closes, new cycles are decoded only after REC_CYCLES consecutive ST_RECOVER samples with `wr_strobe_n`=1. A low write strobe restarts the count.
- R8: Any ST_RECOVER sample with `chip_sel_n`=0 and `protect`=0 is ignored. It leaves the array unchanged and raises `rec_viol` for one cycle after that edge.
- R9: While `protect`=1, no write commits and `data_oe` is 0. A write that is open when `protect` rises is dropped without a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low reset |
| chip_sel_n | input | 1 | Chip select strobe, active low |
| wr_strobe_n | input | 1 | Write strobe, active low |
| out_en_n | input | 1 | Output enable, active low |
| protect | input | 1 | Forces all strobes to be ignored |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data from the bus |
| rdata | output | DATA_W | Read data, zero when not driven |
| data_oe | output | 1 | Data bus drive enable |
| commit | output | 1 | One-cycle pulse when a write is stored |
| addr_err | output | 1 | One-cycle pulse when a write is dropped for an address change |
| rec_viol | output | 1 | One-cycle pulse when a strobe arrives during recovery |

## Verification
The pulses `commit`, `addr_err` and `rec_viol` and all state changes appear one edge after the sample that causes them. `data_oe` and `rdata` combine the state from that edge with the current `out_en_n` and `addr`. After reset, a write closed on sample n reopens decoding no earlier than sample n+REC_CYCLES+1. The bench drives each vector one time unit after a rising edge and compares every output one time unit after the next rising edge. Each comparison therefore sees exactly one registered step from the vector that caused it.

// File: rtl/sdec_pkg.sv
package sdec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_READ    = 2'd1,
        ST_WRITE   = 2'd2,
        ST_RECOVER = 2'd3
    } sdec_state_e;
endpackage

// File: rtl/sdec_rec_timer.sv
// Counts consecutive write-strobe-high samples while recovery is active.
module sdec_rec_timer #(
    parameter int REC_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic active,
    input  logic strobe_high,
    output logic done
);
    localparam int CW = (REC_CYCLES > 1) ? $clog2(REC_CYCLES + 1) : 1;
    localparam logic [CW-1:0] LAST = CW'(REC_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (active) begin
            if (strobe_high) begin
                cnt <= cnt + CW'(1);
            end else begin
                cnt <= '0;
            end
        end
    end

    assign done = active && strobe_high && (cnt == LAST);
endmodule

// File: rtl/sdec_store.sv
// Small byte array: one synchronous write port, one combinational read port.
module sdec_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/sram_cycle_decoder.sv
module sram_cycle_decoder
    import sdec_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int REC_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic              wr_strobe_n,
    input  logic              out_en_n,
    input  logic              protect,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              data_oe,
    output logic              commit,
    output logic              addr_err,
    output logic              rec_viol
);
    sdec_state_e       state, state_nxt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              moved_q;
    logic              commit_q, err_q, viol_q;

    logic both_low, rd_req, released;
    logic wr_start, wr_hold, wr_end, viol_go;
    logic rec_done;
    logic [DATA_W-1:0] store_rd;

    assign both_low = !chip_sel_n && !wr_strobe_n;
    assign rd_req   = !chip_sel_n &&  wr_strobe_n;
    assign released =  chip_sel_n ||  wr_strobe_n;

    // Next-state decode
    always_comb begin
        state_nxt = state;
        if (protect) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_READ: begin
                    if (both_low)    state_nxt = ST_WRITE;
                    else if (rd_req) state_nxt = ST_READ;
                    else             state_nxt = ST_IDLE;
                end
                ST_WRITE: begin
                    if (released) state_nxt = ST_RECOVER;
                end
                ST_RECOVER: begin
                    if (rec_done) state_nxt = ST_IDLE;
                end
            endcase
        end
    end

    // Cycle events
    always_comb begin
        wr_start = !protect && ((state == ST_IDLE) || (state == ST_READ)) && both_low;
        wr_hold  = !protect && (state == ST_WRITE) && both_low;
        wr_end   = !protect && (state == ST_WRITE) && released;
        viol_go  = !protect && (state == ST_RECOVER) && !chip_sel_n;
    end

    // State register, capture registers and event pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            addr_q   <= '0;
            data_q   <= '0;
            moved_q  <= 1'b0;
            commit_q <= 1'b0;
            err_q    <= 1'b0;
            viol_q   <= 1'b0;
        end else begin
            state    <= state_nxt;
            commit_q <= wr_end && !moved_q;
            err_q    <= wr_end &&  moved_q;
            viol_q   <= viol_go;
            if (wr_start) begin
                addr_q  <= addr;
                data_q  <= wdata;
                moved_q <= 1'b0;
            end else if (wr_hold) begin
                data_q  <= wdata;
                if (addr != addr_q) moved_q <= 1'b1;
            end
        end
    end

    sdec_rec_timer #(
        .REC_CYCLES(REC_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (wr_end),
        .active     (state == ST_RECOVER),
        .strobe_high(wr_strobe_n),
        .done       (rec_done)
    );

    sdec_store #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_end && !moved_q),
        .wr_addr(addr_q),
        .wr_data(data_q),
        .rd_addr(addr),
        .rd_data(store_rd)
    );

    // Outputs
    always_comb begin
        data_oe  = (state == ST_READ) && !out_en_n && !protect;
        rdata    = data_oe ? store_rd : '0;
        commit   = commit_q;
        addr_err = err_q;
        rec_viol = viol_q;
    end
endmodule

// File: rtl/sdec_checker.sv
module sdec_checker (
    input logic clk,
    input logic rst_n,
    input logic chip_sel_n,
    input logic wr_strobe_n,
    input logic protect,
    input logic data_oe,
    input logic commit,
    input logic addr_err,
    input logic rec_viol
);
    // R9: a protected sample never produces a commit
    a_r9_protect_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        protect |=> !commit);

    // R9: no bus drive while protected
    a_r9_protect_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        protect |-> !data_oe);

    // R4, R7: commits are single-cycle and separated by recovery
    a_r4_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R6: a closing write either commits or errors, never both
    a_r6_err_excludes_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && addr_err));

    // R2: bus drive only follows a read request sample
    a_r2_drive_after_read_req: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> $past(!chip_sel_n && wr_strobe_n && !protect));

    // R8: a recovery violation never coincides with a commit
    a_r8_viol_not_commit: assert property (@(posedge clk) disable iff (!rst_n)
        rec_viol |-> !commit);
endmodule

bind sram_cycle_decoder sdec_checker u_sdec_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_sel_n (chip_sel_n),
    .wr_strobe_n(wr_strobe_n),
    .protect    (protect),
    .data_oe    (data_oe),
    .commit     (commit),
    .addr_err   (addr_err),
    .rec_viol   (rec_viol)
);

// File: tb/test_sram_cycle_decoder.sv
module test_sram_cycle_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_sel_n = 1'b1;
    logic       wr_strobe_n = 1'b1;
    logic       out_en_n = 1'b1;
    logic       protect = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       data_oe, commit, addr_err, rec_viol;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    sram_cycle_decoder #(.ADDR_W(4), .DATA_W(8), .REC_CYCLES(3)) i_sram_cycle_decoder (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .wr_strobe_n(wr_strobe_n),
        .out_en_n(out_en_n), .protect(protect), .addr(addr), .wdata(wdata),
        .rdata(rdata), .data_oe(data_oe), .commit(commit), .addr_err(addr_err),
        .rec_viol(rec_viol)
    );

    // Row: {cs_n, wr_n, oe_n, prot, addr[4], wdata[8] | exp_oe, exp_rdata[8], exp_commit, exp_err, exp_viol}
    localparam int NV = 54;
    localparam logic [27:0] VEC [NV] = '{
        {4'b1110, 4'h0, 8'h00, 1'b0, 8'h00, 3'b000}, // 0 idle
        {4'b0010, 4'h3, 8'hA5, 1'b0, 8'h00, 3'b000}, // 1 R3 write opens
        {4'b0010, 4'h3, 8'hA5, 1'b0, 8'h00, 3'b000}, // 2 hold
        {4'b0110, 4'h3, 8'h00, 1'b0, 8'h00, 3'b100}, // 3 R4 write strobe rises, commit
        {4'b1110, 4'h3, 8'h00, 1'b0, 8'h00, 3'b000}, // 4 R7 recovery 1
        {4'b1110, 4'h3, 8'h00, 1'b0, 8'h00, 3'b000}, // 5 recovery 2
        {4'b1110, 4'h3, 8'h00, 1'b0, 8'h00, 3'b000}, // 6 recovery 3 -> idle
        {4'b0100, 4'h3, 8'h00, 1'b1, 8'hA5, 3'b000}, // 7 R2 read
        {4'b0110, 4'h3, 8'h00, 1'b0, 8'h00, 3'b000}, // 8 read, oe off
        {4'b1100, 4'h3, 8'h00, 1'b0, 8'h00, 3'b000}, // 9 R5 idle with oe low
        {4'b0010, 4'h5, 8'h3C, 1'b0, 8'h00, 3'b000}, // 10 write opens at 5
        {4'b0010, 4'h6, 8'h3C, 1'b0, 8'h00, 3'b000}, // 11 R6 address moves
        {4'b1010, 4'h6, 8'h3C, 1'b0, 8'h00, 3'b010}, // 12 select rises, error
        {4'b1110, 4'h6, 8'h00, 1'b0, 8'h00, 3'b000}, // 13 recovery 1
        {4'b1110, 4'h6, 8'h00, 1'b0, 8'h00, 3'b000}, // 14 recovery 2
        {4'b0100, 4'h3, 8'h00, 1'b0, 8'h00, 3'b001}, // 15 R8 strobe on final recovery sample
        {4'b0100, 4'h5, 8'h00, 1'b1, 8'h00, 3'b000}, // 16 R6 dropped write left 0
        {4'b1110, 4'h0, 8'h00, 1'b0, 8'h00, 3'b000}, // 17
        {4'b0010, 4'h9, 8'h81, 1'b0, 8'h00, 3'b000}, // 18 write opens at 9
        {4'b0110, 4'h9, 8'h00, 1'b0, 8'h00, 3'b100}, // 19 commit
        {4'b0010, 4'h2, 8'hFF, 1'b0, 8'h00, 3'b001}, // 20 R8 write attempt in recovery
        {4'b1110, 4'h2, 8'h00, 1'b0, 8'h00, 3'b000}, // 21 R7 count restarted
        {4'b1110, 4'h2, 8'h00, 1'b0, 8'h00, 3'b000}, // 22
        {4'b1110, 4'h2, 8'h00, 1'b0, 8'h00, 3'b000}, // 23 -> idle
        {4'b0100, 4'h2, 8'h00, 1'b1, 8'h00, 3'b000}, // 24 R8 ignored write absent
        {4'b0100, 4'h9, 8'h00, 1'b1, 8'h81, 3'b000}, // 25 read 9
        {4'b1111, 4'h0, 8'h00, 1'b0, 8'h00, 3'b000}, // 26 R9 protect
        {4'b0011, 4'h4, 8'h77, 1'b0, 8'h00, 3'b000}, // 27 protected write
        {4'b0101, 4'h9, 8'h00, 1'b0, 8'h00, 3'b000}, // 28 protected read
        {4'b1110, 4'h0, 8'h00, 1'b0, 8'h00, 3'b000}, // 29
        {4'b0100, 4'h4, 8'h00, 1'b1, 8'h00, 3'b000}, // 30 R9 addr 4 untouched
        {4'b1110, 4'h0, 8'h00, 1'b0, 8'h00, 3'b000}, // 31
        {4'b1010, 4'h7, 8'h11, 1'b0, 8'h00, 3'b000}, // 32 R3 write strobe first
        {4'b0010, 4'h7, 8'h22, 1'b0, 8'h00, 3'b000}, // 33 select falls later, opens
        {4'b0010, 4'h7, 8'h33, 1'b0, 8'h00, 3'b000}, // 34 data updates
        {4'b1010, 4'h7, 8'h44, 1'b0, 8'h00, 3'b100}, // 35 R4 select rises first
        {4'b1110, 4'h7, 8'h00, 1'b0, 8'h00, 3'b000}, // 36
        {4'b1110, 4'h7, 8'h00, 1'b0, 8'h00, 3'b000}, // 37
        {4'b1110, 4'h7, 8'h00, 1'b0, 8'h00, 3'b000}, // 38
        {4'b0100, 4'h7, 8'h00, 1'b1, 8'h33, 3'b000}, // 39 R3 last overlap byte stored
        {4'b1110, 4'h0, 8'h00, 1'b0, 8'h00, 3'b000}, // 40
        {4'b0100, 4'h1, 8'h00, 1'b1, 8'h00, 3'b000}, // 41 read 1
        {4'b0000, 4'h1, 8'h5A, 1'b0, 8'h00, 3'b000}, // 42 R5 read turns into write
        {4'b1000, 4'h1, 8'h5A, 1'b0, 8'h00, 3'b100}, // 43 commit
        {4'b1110, 4'h1, 8'h00, 1'b0, 8'h00, 3'b000}, // 44
        {4'b1110, 4'h1, 8'h00, 1'b0, 8'h00, 3'b000}, // 45
        {4'b1110, 4'h1, 8'h00, 1'b0, 8'h00, 3'b000}, // 46
        {4'b0100, 4'h1, 8'h00, 1'b1, 8'h5A, 3'b000}, // 47 read 1
        {4'b1110, 4'h0, 8'h00, 1'b0, 8'h00, 3'b000}, // 48
        {4'b0010, 4'h8, 8'h99, 1'b0, 8'h00, 3'b000}, // 49 write opens at 8
        {4'b0011, 4'h8, 8'h99, 1'b0, 8'h00, 3'b000}, // 50 R9 protect aborts
        {4'b1110, 4'h8, 8'h00, 1'b0, 8'h00, 3'b000}, // 51 no late commit
        {4'b0100, 4'h8, 8'h00, 1'b1, 8'h00, 3'b000}, // 52 addr 8 untouched
        {4'b1110, 4'h0, 8'h00, 1'b0, 8'h00, 3'b000}  // 53
    };

    function automatic string row_req(int i);
        if ((i >= 4 && i <= 6) || (i >= 13 && i <= 15) || (i >= 21 && i <= 23)) return "R7";
        if ((i >= 26 && i <= 30) || (i >= 49 && i <= 52)) return "R9";
        if (i == 1 || i == 2 || i == 32 || i == 33 || i == 34 || i == 39) return "R3";
        if (i == 20 || i == 24) return "R8";
        return "R2";
    endfunction

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_idle_outputs(string req);
        check(req, "data_oe",  {7'd0, data_oe},  8'h00);
        check(req, "rdata",    rdata,            8'h00);
        check(req, "commit",   {7'd0, commit},   8'h00);
        check(req, "addr_err", {7'd0, addr_err}, 8'h00);
        check(req, "rec_viol", {7'd0, rec_viol}, 8'h00);
    endtask

    initial begin
        // R1: reset state
        repeat (3) tick();
        check_idle_outputs("R1");
        rst_n = 1'b1;
        tick();
        check_idle_outputs("R1");

        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            string rq;
            v = VEC[i];
            chip_sel_n  = v[27];
            wr_strobe_n = v[26];
            out_en_n    = v[25];
            protect     = v[24];
            addr        = v[23:20];
            wdata       = v[19:12];
            tick();
            rq = row_req(i);
            check(rq, $sformatf("row %0d data_oe (R2 R5)", i), {7'd0, data_oe}, {7'd0, v[11]});
            check(rq, $sformatf("row %0d rdata (R2)", i), rdata, v[10:3]);
            check(rq, $sformatf("row %0d commit (R4)", i), {7'd0, commit}, {7'd0, v[2]});
            check(rq, $sformatf("row %0d addr_err (R6)", i), {7'd0, addr_err}, {7'd0, v[1]});
            check(rq, $sformatf("row %0d rec_viol (R8)", i), {7'd0, rec_viol}, {7'd0, v[0]});
        end

        // R1: reset clears the array (address 9 held 0x81)
        rst_n = 1'b0;
        chip_sel_n = 1'b1; wr_strobe_n = 1'b1; out_en_n = 1'b1; protect = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        chip_sel_n = 1'b0; out_en_n = 1'b0; addr = 4'h9;
        tick();
        check("R1", "data_oe after reset read", {7'd0, data_oe}, 8'h01);
        check("R1", "array cleared by reset", rdata, 8'h00);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule